// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is a four-wire synchronous serial slave that lets a host microcontroller read and write a 64-entry byte register file. The host frames each exchange with an active-low chip select and clocks bytes in and out, most significant bit first. The first byte of every command carries a 2-bit operation code in bits 7:6 and a 6-bit register address in bits 5:0. The operations are pipelined read, no-operation, single write and burst write.

Reads are pipelined by one byte. The data fetched by a read command appears in the byte that follows it, while the host may already shift in the next command. Every write is followed by a readback of the same register, and that readback does not clear clear-on-read bits. A burst write keeps writing to one fixed address until chip select rises. Addresses marked in a per-address mask return 0x00 on their post-write readback.

The serial pins are brought into the system clock domain through two-flop synchronizers, and edges are detected there. The control is a six-state machine:

- `ST_IDLE`: chip select is high.
- `ST_CMD`: waiting for a command byte.
- `ST_RD_FETCH`: a one-cycle clearing read.
- `ST_WDATA`: waiting for a write data byte.
- `ST_WR_COMMIT`: a one-cycle write.
- `ST_WR_BACK`: a one-cycle non-clearing readback.

The transitions are:

- IDLE→CMD when chip select goes low.
- CMD→RD_FETCH on a read byte.
- CMD→CMD on a no-operation byte.
- CMD→WDATA on a write or burst byte.
- RD_FETCH→CMD.
- WDATA→WR_COMMIT when a data byte completes.
- WR_COMMIT→WR_BACK.
- WR_BACK→WDATA in a burst, and WR_BACK→CMD otherwise.
- Any state→IDLE when chip select goes high. The one-cycle states first finish their access.

Top module: `serial_reg_slave`

## Requirements
- R1: While chip select (cs_n) is high, sdo is 0. Out of reset no register-file strobe is issued.
- R2: sdi is sampled on the rising edge of sck, and sdo changes after the falling edge of sck. Both directions carry the most significant bit first, and a byte ends at the eighth falling edge.
- R3: The first byte of a command is decoded as operation = bits 7:6 and register address = bits 5:0, so all 64 addresses 0x00..0x3F are reachable.
- R4: Operation 00 (read) issues exactly one one-cycle rf_rd_clr strobe at the address it carries. The fetched value is shifted out in the next byte.
- R5: rf_rd_clr is never asserted for a no-operation or for a post-write readback. Those accesses leave clear-on-read contents unchanged.
- R6: Operation 01 (no-operation) makes no register-file access. The next byte shifts out the held last-read value again.
- R7: Operation 10 (single write) writes the second byte to the addressed register with a one-cycle rf_we. The byte after it shifts out that register's readback.
- R8: Operation 11 (burst write) writes every byte after the command byte to the same address, with a readback after each write, until chip select rises.
- R9: For an address whose bit is set in UNDEF_MASK (by default only 0x20), the post-write readback returns 0x00.
- R10: A byte cut short by chip select rising causes no register-file access.
- R11: The first byte after chip select falls shifts out the last read or readback value, held across transactions. That value is 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| rf_addr | output | 6 | Register-file address |
| rf_wdata | output | 8 | Register-file write data |
| rf_we | output | 1 | One-cycle write enable |
| rf_rd_clr | output | 1 | One-cycle strobe marking a clearing read |
| rf_rdata | input | 8 | Register-file read data (combinational) |

## Verification
On every clock, assertions check four things:

- Both strobes are single-cycle, and they never coincide.
- Each write is followed directly by the non-clearing readback state.
- A clearing read only ever follows the command state.
- sdo stays quiet in the idle state.

The following can only be shown by the bench scenarios, which compare the serial output stream against arithmetic expectations:

- the one-byte read pipeline, over a sweep of all 64 addresses;
- the write-then-readback value;
- burst sequencing to one address;
- the masked undefined readback;
- survival of clear-on-read contents across non-clearing accesses;
- the discarding of a truncated byte.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_RD_FETCH,
        ST_WDATA,
        ST_WR_COMMIT,
        ST_WR_BACK
    } srs_state_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_NOP   = 2'b01,
        OP_WRITE = 2'b10,
        OP_BURST = 2'b11
    } srs_op_e;

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int        W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            logic meta_q;
            logic stab_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[gi];
                    stab_q <= RST_VAL[gi];
                end else begin
                    meta_q <= async_in[gi];
                    stab_q <= meta_q;
                end
            end
            assign sync_out[gi] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/srs_shifter.sv
module srs_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          sdi,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic [DW-1:0] rx_byte,
    output logic          byte_done,
    output logic          tx_msb
);

    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic [CW-1:0] cnt_q;
    logic [DW-1:0] rx_q;
    logic [DW-1:0] tx_q;

    assign byte_done = active && sck_fall && (cnt_q == LAST);
    assign rx_byte   = rx_q;
    assign tx_msb    = tx_q[DW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rx_q  <= '0;
        end else if (!active) begin
            cnt_q <= '0;
            rx_q  <= '0;
        end else begin
            if (sck_rise) begin
                rx_q <= {rx_q[DW-2:0], sdi};
            end
            if (sck_fall) begin
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_data;
        end else if (!active) begin
            tx_q <= '0;
        end else if (sck_fall && (cnt_q != LAST)) begin
            tx_q <= {tx_q[DW-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
    import srs_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 8,
    parameter logic [(2**AW)-1:0] UNDEF_MASK = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          byte_done,
    input  logic [DW-1:0] rx_byte,
    input  logic [DW-1:0] rf_rdata,
    output logic [AW-1:0] rf_addr,
    output logic [DW-1:0] rf_wdata,
    output logic          rf_we,
    output logic          rf_rd_clr,
    output logic          tx_load,
    output logic [DW-1:0] tx_data,
    output srs_state_e    state
);

    srs_state_e    state_q;
    srs_state_e    state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          burst_q;
    logic [DW-1:0] hold_q;
    srs_op_e       op;
    logic [DW-1:0] back_val;

    assign op       = srs_op_e'(rx_byte[DW-1 -: 2]);
    assign back_val = UNDEF_MASK[addr_q] ? '0 : rf_rdata;
    assign state    = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (active) state_d = ST_CMD;
            ST_CMD: begin
                if (!active) begin
                    state_d = ST_IDLE;
                end else if (byte_done) begin
                    unique case (op)
                        OP_READ:  state_d = ST_RD_FETCH;
                        OP_NOP:   state_d = ST_CMD;
                        OP_WRITE,
                        OP_BURST: state_d = ST_WDATA;
                    endcase
                end
            end
            ST_RD_FETCH:  state_d = active ? ST_CMD : ST_IDLE;
            ST_WDATA: begin
                if (!active)        state_d = ST_IDLE;
                else if (byte_done) state_d = ST_WR_COMMIT;
            end
            ST_WR_COMMIT: state_d = ST_WR_BACK;
            ST_WR_BACK: begin
                if (!active)     state_d = ST_IDLE;
                else if (burst_q) state_d = ST_WDATA;
                else             state_d = ST_CMD;
            end
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rf_addr   = addr_q;
        rf_wdata  = wdata_q;
        rf_we     = 1'b0;
        rf_rd_clr = 1'b0;
        tx_load   = 1'b0;
        tx_data   = hold_q;
        unique case (state_q)
            ST_IDLE:      tx_load = active;
            ST_CMD,
            ST_WDATA:     tx_load = byte_done;
            ST_RD_FETCH: begin
                rf_rd_clr = 1'b1;
                tx_load   = 1'b1;
                tx_data   = rf_rdata;
            end
            ST_WR_COMMIT: rf_we = 1'b1;
            ST_WR_BACK: begin
                tx_load = 1'b1;
                tx_data = back_val;
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            burst_q <= 1'b0;
            hold_q  <= '0;
        end else begin
            if (state_q == ST_CMD && active && byte_done) begin
                addr_q  <= rx_byte[AW-1:0];
                burst_q <= (op == OP_BURST);
            end
            if (state_q == ST_WDATA && active && byte_done) begin
                wdata_q <= rx_byte;
            end
            if (state_q == ST_RD_FETCH) hold_q <= rf_rdata;
            if (state_q == ST_WR_BACK)  hold_q <= back_val;
        end
    end

endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
    import srs_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 8,
    parameter logic [(2**AW)-1:0] UNDEF_MASK = (2**AW)'(1) << 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          sdi,
    output logic          sdo,
    output logic [AW-1:0] rf_addr,
    output logic [DW-1:0] rf_wdata,
    output logic          rf_we,
    output logic          rf_rd_clr,
    input  logic [DW-1:0] rf_rdata
);

    localparam int NSYNC = 3;

    logic [NSYNC-1:0] pins_s;
    logic             cs_n_s;
    logic             sck_s;
    logic             sdi_s;
    logic             sck_prev_q;
    logic             active;
    logic             sck_rise;
    logic             sck_fall;
    logic             byte_done;
    logic [DW-1:0]    rx_byte;
    logic             tx_load;
    logic [DW-1:0]    tx_data;
    logic             tx_msb;
    srs_state_e       fsm_state;

    srs_sync #(.W(NSYNC), .RST_VAL(3'b100)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, sck, sdi}),
        .sync_out (pins_s)
    );

    assign cs_n_s = pins_s[2];
    assign sck_s  = pins_s[1];
    assign sdi_s  = pins_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= sck_s;
    end

    assign active   = !cs_n_s;
    assign sck_rise = sck_s && !sck_prev_q;
    assign sck_fall = !sck_s && sck_prev_q;

    srs_shifter #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .sdi       (sdi_s),
        .load      (tx_load),
        .load_data (tx_data),
        .rx_byte   (rx_byte),
        .byte_done (byte_done),
        .tx_msb    (tx_msb)
    );

    srs_ctrl #(.AW(AW), .DW(DW), .UNDEF_MASK(UNDEF_MASK)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .rf_rdata  (rf_rdata),
        .rf_addr   (rf_addr),
        .rf_wdata  (rf_wdata),
        .rf_we     (rf_we),
        .rf_rd_clr (rf_rd_clr),
        .tx_load   (tx_load),
        .tx_data   (tx_data),
        .state     (fsm_state)
    );

    assign sdo = tx_msb;

endmodule

// File: rtl/serial_reg_slave_chk.sv
module serial_reg_slave_chk
    import srs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sdo,
    input logic       rf_we,
    input logic       rf_rd_clr,
    input srs_state_e state
);

    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sdo); // R1

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_clr |=> !rf_rd_clr); // R4

    AST_CLR_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_clr |-> ($past(state) == ST_CMD)); // R4

    AST_NO_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !rf_rd_clr); // R5

    AST_BACK_NOCLR: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> ((state == ST_WR_BACK) && !rf_rd_clr)); // R5

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we); // R7

endmodule

bind serial_reg_slave serial_reg_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdo       (sdo),
    .rf_we     (rf_we),
    .rf_rd_clr (rf_rd_clr),
    .state     (fsm_state)
);

// File: tb/serial_reg_slave_test.sv
`timescale 1ns/1ps
module serial_reg_slave_test;

    localparam logic [5:0] COR_ADDR   = 6'h3E;
    localparam logic [5:0] UNDEF_ADDR = 6'h20;
    localparam int         HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo;
    logic [5:0] rf_addr;
    logic [7:0] rf_wdata;
    logic       rf_we;
    logic       rf_rd_clr;
    logic [7:0] rf_rdata;

    logic [7:0] rf_mem [64];
    logic [7:0] exp_mem [64];
    logic [7:0] exp_hold;
    int         we_cnt;
    int         clr_cnt;
    int         checks;
    int         errors;
    bit         done;

    always #10 clk = ~clk;

    serial_reg_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .sdi       (sdi),
        .sdo       (sdo),
        .rf_addr   (rf_addr),
        .rf_wdata  (rf_wdata),
        .rf_we     (rf_we),
        .rf_rd_clr (rf_rd_clr),
        .rf_rdata  (rf_rdata)
    );

    // register file model with one clear-on-read location
    assign rf_rdata = rf_mem[rf_addr];
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) rf_mem[i] <= 8'h00;
            we_cnt  <= 0;
            clr_cnt <= 0;
        end else begin
            if (rf_we) begin
                rf_mem[rf_addr] <= rf_wdata;
                we_cnt <= we_cnt + 1;
            end else if (rf_rd_clr) begin
                if (rf_addr == COR_ADDR) rf_mem[rf_addr] <= 8'h00;
                clr_cnt <= clr_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            sdi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = sdo;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] exp, input string req);
        logic [7:0] rx;
        shift_bits(tx, 8, rx);
        chk(req, rx, exp);
    endtask

    task automatic cs_on();
        @(negedge clk);
        cs_n = 1'b0;
    endtask

    task automatic cs_off();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (HALF + 4) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 8'hFF);
    endfunction

    initial begin
        int we0;
        int clr0;
        logic [7:0] rb;
        logic [7:0] junk;

        checks = 0;
        errors = 0;
        done   = 1'b0;
        for (int i = 0; i < 64; i++) exp_mem[i] = 8'h00;
        exp_hold = 8'h00;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 sdo idle after reset", sdo, 0);
        chk("R1 no strobes after reset", we_cnt + clr_cnt, 0);

        // R7, R3, R9, R11: single write sweep over all addresses
        for (int a = 0; a < 64; a++) begin
            we0 = we_cnt; clr0 = clr_cnt;
            cs_on();
            xfer({2'b10, 6'(a)}, exp_hold, "R11 first byte holds last read");
            xfer(pat(a), exp_hold, "R7 data byte returns held value");
            exp_mem[a] = pat(a);
            rb = (6'(a) == UNDEF_ADDR) ? 8'h00 : pat(a);
            xfer(8'h40, rb, (6'(a) == UNDEF_ADDR) ? "R9 masked readback" : "R7 readback R3");
            exp_hold = rb;
            cs_off();
            chk("R7 one write strobe", we_cnt - we0, 1);
            chk("R5 write readback does not clear", clr_cnt - clr0, 0);
            chk("R1 sdo low between frames", sdo, 0);
        end

        // R4, R2, R3: pipelined read of every address in one frame
        clr0 = clr_cnt;
        cs_on();
        xfer(8'h00, exp_hold, "R11 first read byte");
        for (int a = 1; a < 64; a++) begin
            xfer({2'b00, 6'(a)}, exp_mem[a-1], "R4 R2 pipelined read data");
            if (6'(a - 1) == COR_ADDR) exp_mem[a-1] = 8'h00;
        end
        xfer(8'h40, exp_mem[63], "R4 last read via nop");
        exp_hold = exp_mem[63];
        cs_off();
        chk("R4 one clearing strobe per read", clr_cnt - clr0, 64);

        // R4: clear-on-read location has been cleared by the read
        cs_on();
        xfer({2'b00, COR_ADDR}, exp_hold, "R4 cor read cmd");
        xfer(8'h40, 8'h00, "R4 cor cleared after read");
        exp_hold = 8'h00;
        cs_off();

        // R5: writes and nops leave the clear-on-read contents alone
        clr0 = clr_cnt;
        cs_on();
        xfer({2'b10, COR_ADDR}, exp_hold, "R5 cmd");
        xfer(8'h5A, exp_hold, "R5 data");
        xfer(8'h40, 8'h5A, "R5 readback keeps cor");
        xfer(8'h40, 8'h5A, "R5 nop keeps hold");
        xfer({2'b00, COR_ADDR}, 8'h5A, "R5 read cmd");
        xfer({2'b00, COR_ADDR}, 8'h5A, "R5 cor survived readback");
        xfer(8'h40, 8'h00, "R4 cor cleared by second read");
        exp_hold = 8'h00;
        cs_off();
        chk("R5 clearing strobes only for reads", clr_cnt - clr0, 2);

        // R8: burst to one address
        we0 = we_cnt;
        cs_on();
        xfer({2'b11, 6'h05}, exp_hold, "R8 burst cmd");
        xfer(8'hA1, exp_hold, "R8 first burst byte");
        xfer(8'hB2, 8'hA1, "R8 readback 1");
        xfer(8'hC3, 8'hB2, "R8 readback 2");
        xfer(8'hD4, 8'hC3, "R8 readback 3");
        cs_off();
        chk("R8 burst write count", we_cnt - we0, 4);
        exp_hold = 8'hD4;
        cs_on();
        xfer({2'b00, 6'h05}, exp_hold, "R11 hold after burst");
        xfer({2'b00, 6'h04}, 8'hD4, "R8 final value");
        xfer(8'h40, pat(4), "R8 neighbour untouched");
        exp_hold = pat(4);
        cs_off();

        // R9: burst to masked address
        cs_on();
        xfer({2'b11, UNDEF_ADDR}, exp_hold, "R9 burst cmd");
        xfer(8'h11, exp_hold, "R9 burst byte");
        xfer(8'h22, 8'h00, "R9 masked burst readback");
        xfer(8'h40, 8'h00, "R9 masked burst readback 2");
        exp_hold = 8'h00;
        cs_off();

        // R6: no-operation
        we0 = we_cnt; clr0 = clr_cnt;
        cs_on();
        xfer(8'h40, exp_hold, "R6 nop first");
        xfer(8'h7F, exp_hold, "R6 nop repeats hold");
        xfer(8'h55, exp_hold, "R6 nop keeps hold");
        cs_off();
        chk("R6 nop makes no access", (we_cnt - we0) + (clr_cnt - clr0), 0);

        // R10: truncated data byte is discarded
        we0 = we_cnt;
        cs_on();
        xfer({2'b10, 6'h07}, exp_hold, "R10 cmd");
        shift_bits(8'hFF, 5, junk);
        cs_off();
        chk("R10 no write on truncated byte", we_cnt - we0, 0);
        cs_on();
        xfer({2'b00, 6'h07}, exp_hold, "R10 read cmd");
        xfer(8'h40, pat(7), "R10 register unchanged");
        cs_off();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule